// File: doc/BRIEF.md
# Highway and Farm Road Signal Sequencer

This block drives the signal lamps where a busy highway crosses a lightly used farm road. The highway keeps right of way for as long as no vehicle waits on the farm road. When a vehicle is sensed there, the highway keeps its green until it has had a full long interval of it. It then passes through yellow, and the farm road gets green. The farm road keeps green only while a vehicle is still sensed, and never for more than one long interval. It then passes through its own yellow and hands right of way back to the highway.

A single interval timer serves every phase. It restarts on each phase change and reports two level flags, one for the short (yellow) interval and one for the long (green) interval. Both flags stay high until the next restart. The interval lengths are parameters. A parameter selects a binary or a one-hot phase register, and both give the same behaviour. The lamp outputs are registered.

Top module: `tlc_ctrl`

## Requirements
- R1: In every cycle at least one of the two roads shows red (code 10), so the two roads never show green or yellow at the same time.
- R2: While `car_wait` is low, the highway stays green (code 00) and the farm road stays red, for any number of cycles.
- R3: The highway leaves green only in a cycle where `car_wait` is high, and only once the highway has shown green for at least LONG_CYC cycles. With `car_wait` held high, highway green lasts exactly LONG_CYC cycles.
- R4: Each yellow phase (code 01) lasts exactly SHORT_CYC cycles. Highway yellow is followed by farm green, and farm yellow by highway green.
- R5: Farm green turns to farm yellow in the cycle after the first clock edge at which `car_wait` is sampled low, or after LONG_CYC cycles of farm green, whichever comes first.
- R6: The interval timer restarts on every phase change, so each interval is measured from the first cycle of the current phase.
- R7: Lamp codes are 00 for green, 01 for yellow and 10 for red. Code 11 never appears on either output.
- R8: A synchronous active-high `rst` gives highway green and farm red in the cycle after the edge, and restarts the interval timer. This holds from any phase.
- R9: The binary phase register (highway green 00, highway yellow 01, farm green 11, farm yellow 10) and the one-hot variant produce identical lamp outputs cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| car_wait | input | 1 | High while a vehicle is sensed on the farm road |
| hwy_lamp | output | 2 | Highway lamp code: 00 green, 01 yellow, 10 red |
| farm_lamp | output | 2 | Farm road lamp code: 00 green, 01 yellow, 10 red |

## Verification
The assertions assume that `car_wait` is a clean synchronous level with no unknown value once reset is released. They also assume that reset is held for at least one edge before the first check. The bench changes `car_wait` only at falling clock edges. It draws random hold lengths that are both shorter and longer than the two intervals, so that early departures, capped farm greens and long idle highway greens all occur. Directed runs measure each phase length and apply reset from inside farm green.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  typedef enum logic [1:0] {
    LAMP_GO      = 2'b00,
    LAMP_CAUTION = 2'b01,
    LAMP_STOP    = 2'b10
  } lamp_t;

  typedef enum logic [1:0] {
    PH_HWY_GO       = 2'b00,
    PH_HWY_CAUTION  = 2'b01,
    PH_FARM_GO      = 2'b11,
    PH_FARM_CAUTION = 2'b10
  } phase_t;

  // Phase advance rule shared by both register encodings.
  function automatic phase_t phase_step(phase_t cur, logic car, logic short_done,
                                        logic long_done);
    phase_t nxt;
    nxt = cur;
    case (cur)
      PH_HWY_GO:       if (car && long_done) nxt = PH_HWY_CAUTION;
      PH_HWY_CAUTION:  if (short_done) nxt = PH_FARM_GO;
      PH_FARM_GO:      if (!car || long_done) nxt = PH_FARM_CAUTION;
      PH_FARM_CAUTION: if (short_done) nxt = PH_HWY_GO;
      default:         nxt = PH_HWY_GO;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
  parameter int SHORT_CYC = 4,
  parameter int LONG_CYC  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic short_done,
  output logic long_done
);
  localparam int CW = (LONG_CYC > 2) ? $clog2(LONG_CYC) : 1;
  localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_CYC - 1);

  logic [CW-1:0] elapsed;

  // Saturating count of cycles spent in the current phase.
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      elapsed <= '0;
    end else if (elapsed != LONG_LIM) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  assign short_done = (elapsed >= SHORT_LIM);
  assign long_done  = (elapsed >= LONG_LIM);

endmodule

// File: rtl/tlc_phase_seq.sv
module tlc_phase_seq
  import tlc_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   car,
  input  logic   short_done,
  input  logic   long_done,
  output phase_t cur_phase,
  output phase_t nxt_phase,
  output logic   restart
);

  assign nxt_phase = phase_step(cur_phase, car, short_done, long_done);
  assign restart   = (nxt_phase != cur_phase);

  generate
    if (ONE_HOT) begin : g_onehot
      // bit 0 hwy green, bit 1 hwy yellow, bit 2 farm green, bit 3 farm yellow
      logic [3:0] hot_q;
      logic [3:0] hot_d;

      always_comb begin
        case (nxt_phase)
          PH_HWY_CAUTION:  hot_d = 4'b0010;
          PH_FARM_GO:      hot_d = 4'b0100;
          PH_FARM_CAUTION: hot_d = 4'b1000;
          default:         hot_d = 4'b0001;
        endcase
      end

      always_ff @(posedge clk) begin
        if (rst) hot_q <= 4'b0001;
        else     hot_q <= hot_d;
      end

      always_comb begin
        if (hot_q[1])      cur_phase = PH_HWY_CAUTION;
        else if (hot_q[2]) cur_phase = PH_FARM_GO;
        else if (hot_q[3]) cur_phase = PH_FARM_CAUTION;
        else               cur_phase = PH_HWY_GO;
      end
    end else begin : g_binary
      phase_t ph_q;

      always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_HWY_GO;
        else     ph_q <= nxt_phase;
      end

      assign cur_phase = ph_q;
    end
  endgenerate

endmodule

// File: rtl/tlc_lamp_drive.sv
module tlc_lamp_drive
  import tlc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  phase_t     nxt_phase,
  output logic [1:0] hwy_lamp,
  output logic [1:0] farm_lamp
);

  lamp_t hwy_d;
  lamp_t farm_d;

  always_comb begin
    hwy_d  = LAMP_STOP;
    farm_d = LAMP_STOP;
    case (nxt_phase)
      PH_HWY_GO:       hwy_d  = LAMP_GO;
      PH_HWY_CAUTION:  hwy_d  = LAMP_CAUTION;
      PH_FARM_GO:      farm_d = LAMP_GO;
      PH_FARM_CAUTION: farm_d = LAMP_CAUTION;
      default:         hwy_d  = LAMP_GO;
    endcase
  end

  // Decoded from the next phase, so the lamp flops line up with the phase register.
  always_ff @(posedge clk) begin
    if (rst) begin
      hwy_lamp  <= LAMP_GO;
      farm_lamp <= LAMP_STOP;
    end else begin
      hwy_lamp  <= hwy_d;
      farm_lamp <= farm_d;
    end
  end

endmodule

// File: rtl/tlc_ctrl.sv
module tlc_ctrl
  import tlc_pkg::*;
#(
  parameter int SHORT_CYC = 4,
  parameter int LONG_CYC  = 16,
  parameter bit ONE_HOT   = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       car_wait,
  output logic [1:0] hwy_lamp,
  output logic [1:0] farm_lamp
);

  logic   short_done;
  logic   long_done;
  logic   restart;
  phase_t cur_phase;
  phase_t nxt_phase;

  tlc_interval_timer #(
    .SHORT_CYC(SHORT_CYC),
    .LONG_CYC (LONG_CYC)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .short_done(short_done),
    .long_done (long_done)
  );

  tlc_phase_seq #(
    .ONE_HOT(ONE_HOT)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .car       (car_wait),
    .short_done(short_done),
    .long_done (long_done),
    .cur_phase (cur_phase),
    .nxt_phase (nxt_phase),
    .restart   (restart)
  );

  tlc_lamp_drive u_lamps (
    .clk      (clk),
    .rst      (rst),
    .nxt_phase(nxt_phase),
    .hwy_lamp (hwy_lamp),
    .farm_lamp(farm_lamp)
  );

endmodule

// File: rtl/tlc_ctrl_chk.sv
module tlc_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       car_wait,
  input logic [1:0] hwy_lamp,
  input logic [1:0] farm_lamp
);

  assert_one_red_R1: assert property (@(posedge clk) disable iff (rst)
    (hwy_lamp == 2'b10) || (farm_lamp == 2'b10));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (hwy_lamp == 2'b00 && !car_wait) |=> (hwy_lamp == 2'b00));

  assert_demand_leave_R3: assert property (@(posedge clk) disable iff (rst)
    (hwy_lamp == 2'b01 && $past(hwy_lamp) == 2'b00) |-> $past(car_wait));

  assert_hwy_yellow_next_R4: assert property (@(posedge clk) disable iff (rst)
    (hwy_lamp == 2'b01) |=> (hwy_lamp == 2'b01 || farm_lamp == 2'b00));

  assert_farm_yellow_next_R4: assert property (@(posedge clk) disable iff (rst)
    (farm_lamp == 2'b01) |=> (farm_lamp == 2'b01 || hwy_lamp == 2'b00));

  assert_farm_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (farm_lamp == 2'b00 && !car_wait) |=> (farm_lamp == 2'b01));

  assert_legal_codes_R7: assert property (@(posedge clk) disable iff (rst)
    (hwy_lamp != 2'b11) && (farm_lamp != 2'b11));

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (hwy_lamp == 2'b00 && farm_lamp == 2'b10));

endmodule

bind tlc_ctrl tlc_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .car_wait (car_wait),
  .hwy_lamp (hwy_lamp),
  .farm_lamp(farm_lamp)
);

// File: tb/tlc_ctrl_bench.sv
module tlc_ctrl_bench;
  import tlc_pkg::*;

  localparam int SHORT = 4;
  localparam int LONG  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic car = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] hw_b, fm_b, hw_o, fm_o;

  tlc_ctrl #(.SHORT_CYC(SHORT), .LONG_CYC(LONG), .ONE_HOT(1'b0)) u_tlc_ctrl (
    .clk(clk), .rst(rst), .car_wait(car), .hwy_lamp(hw_b), .farm_lamp(fm_b));

  tlc_ctrl #(.SHORT_CYC(SHORT), .LONG_CYC(LONG), .ONE_HOT(1'b1)) u_tlc_ctrl_oh (
    .clk(clk), .rst(rst), .car_wait(car), .hwy_lamp(hw_o), .farm_lamp(fm_o));

  int total = 0;
  int bad   = 0;
  phase_t m_ph  = PH_HWY_GO;
  int     m_cnt = 0;

  function automatic logic [1:0] exp_hwy(phase_t p);
    if (p == PH_HWY_GO) return 2'b00;
    if (p == PH_HWY_CAUTION) return 2'b01;
    return 2'b10;
  endfunction

  function automatic logic [1:0] exp_farm(phase_t p);
    if (p == PH_FARM_GO) return 2'b00;
    if (p == PH_FARM_CAUTION) return 2'b01;
    return 2'b10;
  endfunction

  // Expected phase from the requirements: green minimum/cap LONG, yellow SHORT.
  function automatic phase_t model_next(phase_t p, logic c, int cnt);
    logic ts, tl;
    ts = (cnt >= SHORT - 1);
    tl = (cnt >= LONG - 1);
    case (p)
      PH_HWY_GO:       return (c && tl) ? PH_HWY_CAUTION : p;
      PH_HWY_CAUTION:  return ts ? PH_FARM_GO : p;
      PH_FARM_GO:      return (!c || tl) ? PH_FARM_CAUTION : p;
      default:         return ts ? PH_HWY_GO : p;
    endcase
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, update the model at the rising
  // edge, compare at the next falling edge.
  task automatic tick(input logic c, input logic r);
    phase_t n;
    car = c;
    rst = r;
    @(posedge clk);
    if (r) begin
      m_ph  = PH_HWY_GO;
      m_cnt = 0;
    end else begin
      n = model_next(m_ph, c, m_cnt);
      if (n != m_ph) m_cnt = 0;
      else if (m_cnt < LONG - 1) m_cnt++;
      m_ph = n;
    end
    @(negedge clk);
    check("R6 highway lamp vs phase model", hw_b, exp_hwy(m_ph));
    check("R6 farm lamp vs phase model", fm_b, exp_farm(m_ph));
    check("R9 one-hot highway lamp", hw_o, hw_b);
    check("R9 one-hot farm lamp", fm_o, fm_b);
    total++;
    if (hw_b != 2'b10 && fm_b != 2'b10) begin
      bad++;
      $display("FAIL R1 both roads open actual=%b/%b expected one at 10", hw_b, fm_b);
    end
    total++;
    if (hw_b == 2'b11 || fm_b == 2'b11) begin
      bad++;
      $display("FAIL R7 illegal code actual=%b/%b expected not 11", hw_b, fm_b);
    end
  endtask

  initial begin
    #(4 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int guard;
    logic held;
    void'($urandom(32'd20240917));
    @(negedge clk);
    tick(1'b0, 1'b1);
    tick(1'b1, 1'b1);
    check("R8 reset highway", hw_b, 2'b00);
    check("R8 reset farm", fm_b, 2'b10);

    // R3: with a car present from reset, highway green lasts exactly LONG.
    n = 1;
    guard = 0;
    tick(1'b1, 1'b0);
    while (hw_b == 2'b00 && guard < 200) begin n++; guard++; tick(1'b1, 1'b0); end
    check_int("R3 highway green length", n, LONG);
    // R4: highway yellow length
    n = 0;
    guard = 0;
    while (hw_b == 2'b01 && guard < 200) begin n++; guard++; tick(1'b1, 1'b0); end
    check_int("R4 highway yellow length", n, SHORT);
    check("R4 farm green after highway yellow", fm_b, 2'b00);
    // R5: farm green capped at LONG with car held
    n = 0;
    guard = 0;
    while (fm_b == 2'b00 && guard < 200) begin n++; guard++; tick(1'b1, 1'b0); end
    check_int("R5 farm green cap", n, LONG);
    n = 0;
    guard = 0;
    while (fm_b == 2'b01 && guard < 200) begin n++; guard++; tick(1'b0, 1'b0); end
    check_int("R4 farm yellow length", n, SHORT);
    check("R4 highway green after farm yellow", hw_b, 2'b00);

    // R2: no car for a long stretch
    held = 1'b1;
    repeat (60) begin
      tick(1'b0, 1'b0);
      if (hw_b != 2'b00 || fm_b != 2'b10) held = 1'b0;
    end
    check_int("R2 highway holds green without car", int'(held), 1);

    // R5: car leaves early in farm green
    guard = 0;
    while (fm_b != 2'b00 && guard < 200) begin guard++; tick(1'b1, 1'b0); end
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    check("R5 farm yellow after car leaves", fm_b, 2'b01);

    // R8: reset from farm green
    guard = 0;
    while (fm_b != 2'b00 && guard < 200) begin guard++; tick(1'b1, 1'b0); end
    tick(1'b1, 1'b1);
    check("R8 reset from farm green highway", hw_b, 2'b00);
    check("R8 reset from farm green farm", fm_b, 2'b10);

    // Random car patterns with varied hold lengths
    repeat (200) begin
      int len;
      logic c;
      len = 1 + int'($urandom % 40);
      c   = ($urandom % 3) != 0;
      repeat (len) tick(c, 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule